// File: doc/BRIEF.md
# SPI Serial-Flash Command Front End

This block is the slave-side entry point of a serial flash device. It watches the chip-select, serial clock and serial data-in pins and rebuilds each transaction as an 8-bit instruction code followed, for commands that need one, by a 24-bit byte address. The instruction is sorted into a small set of command kinds. The kind and the address then go to the downstream array controller as single-cycle strobes on a system clock. When chip-select is released, the block reports whether the frame carried everything its command required.

All three pins are brought into the system clock domain through a synchronizer chain whose length is a parameter. Serial clock edges are found by comparing successive synchronized samples. Both the rising and the falling edge are recognized, so the logic does not care whether the serial clock idles low or high (modes 0 and 3). Frames with instruction codes the block does not know, and frames cut off inside the instruction byte, leave no trace downstream. For commands that return data, a simple shifter drives the serial output from a byte supplied by downstream logic. An output enable stays low whenever that shifter is not in use.

Top module: `spi_cmd_front`

## Requirements
- R1: Serial input bits are taken on rising serial-clock edges, most significant bit first, and an identical bit stream yields identical outputs whether the serial clock idles low (mode 0) or high (mode 3).
- R2: The instruction code sets `cmd_kind` as follows: 03h read -> 1, 02h program -> 2, 20h 4K erase -> 3, 52h 32K erase -> 4, D8h 64K erase -> 5, 06h write enable -> 6, 04h write disable -> 7, 05h status read -> 8; 0 means no command since reset. Read, program and the three erases take an address; the others do not.
- R3: `op_valid` pulses for one cycle after the eighth bit of a known instruction. `cmd_kind` changes only at that pulse, and `op_valid`, `addr_valid` and `frame_end` are never high together.
- R4: For addressed commands, 24 address bits follow the instruction. `cmd_addr` takes the low `ADDR_W` (19) bits of them, so the top five bits are ignored. `addr_done` is high from the 24th bit until chip-select is released, and `cmd_addr` is unchanged by frames that do not deliver all 24 bits.
- R5: An unknown instruction code produces no `op_valid` and no `frame_end`, and all further serial input is ignored until chip-select is released and asserted again.
- R6: If chip-select is released before eight instruction bits have arrived, no strobe is produced and the next frame decodes from its first bit.
- R7: On release of chip-select after a known instruction, `frame_end` pulses once. `frame_ok` is 1 if the command's full header (instruction, plus address when needed) was received, and 0 otherwise.
- R8: `so_oe` is low while chip-select is released and during the instruction and address bits, and is high after the header only for read and status read.
- R9: While `so_oe` is high, each falling serial-clock edge moves `so` to the next bit of `tx_byte`, most significant bit first. `tx_take` pulses each time a new byte is loaded at the first falling edge of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, idle low or high |
| si | input | 1 | Serial data into the device |
| tx_byte | input | DATA_W | Byte to send on the serial output |
| so | output | 1 | Serial data out of the device |
| so_oe | output | 1 | Output enable for `so` (high = drive) |
| tx_take | output | 1 | Pulse: `tx_byte` was loaded into the shifter |
| op_valid | output | 1 | Pulse: known instruction decoded |
| cmd_kind | output | 4 | Decoded command kind (encoding in R2) |
| addr_valid | output | 1 | Pulse: full address received |
| cmd_addr | output | ADDR_W | Address captured from the last full header |
| addr_done | output | 1 | All address bits of the current frame received |
| frame_end | output | 1 | Pulse at chip-select release after a known instruction |
| frame_ok | output | 1 | Whether the last ended frame had a full header |

## Verification
The bench builds the block with its defaults: two synchronizer stages, three address bytes, a 19-bit address and an 8-bit data byte, with the serial clock running sixteen times slower than the system clock. The 19-bit address keeps five ignored upper bits, so addresses with those bits set show the masking. The three-byte address makes truncation at 16 bits a realistic frame to try. Because a serial half-period is eight system cycles, the bench can sample the serial output between the synchronizer delay and the next rising edge, in both clock polarities.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [3:0] {
      K_NONE  = 4'd0,
      K_READ  = 4'd1,
      K_PROG  = 4'd2,
      K_ER4K  = 4'd3,
      K_ER32K = 4'd4,
      K_ER64K = 4'd5,
      K_WREN  = 4'd6,
      K_WRDI  = 4'd7,
      K_STAT  = 4'd8
   } cmd_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_TAIL,
      ST_SKIP
   } frm_state_e;

   typedef struct packed {
      logic      known;
      logic      needs_addr;
      logic      returns_data;
      cmd_kind_e kind;
   } op_class_t;

   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_PROG  = 8'h02;
   localparam logic [7:0] OPC_ER4K  = 8'h20;
   localparam logic [7:0] OPC_ER32K = 8'h52;
   localparam logic [7:0] OPC_ER64K = 8'hD8;
   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_STAT  = 8'h05;

   function automatic op_class_t classify(input logic [7:0] op);
      op_class_t c;
      c = '{known: 1'b1, needs_addr: 1'b0, returns_data: 1'b0, kind: K_NONE};
      case (op)
         OPC_READ:  begin c.kind = K_READ;  c.needs_addr = 1'b1; c.returns_data = 1'b1; end
         OPC_PROG:  begin c.kind = K_PROG;  c.needs_addr = 1'b1; end
         OPC_ER4K:  begin c.kind = K_ER4K;  c.needs_addr = 1'b1; end
         OPC_ER32K: begin c.kind = K_ER32K; c.needs_addr = 1'b1; end
         OPC_ER64K: begin c.kind = K_ER64K; c.needs_addr = 1'b1; end
         OPC_WREN:  c.kind = K_WREN;
         OPC_WRDI:  c.kind = K_WRDI;
         OPC_STAT:  begin c.kind = K_STAT; c.returns_data = 1'b1; end
         default:   c.known = 1'b0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("spi_cmd_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= RST_VAL;
            else        ff <= d;
         end
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= {STAGES{RST_VAL}};
            else        ff <= {ff[STAGES-2:0], d};
         end
         assign q = ff[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_cmd_pins.sv
module spi_cmd_pins #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic cs_act,
   output logic frame_start,
   output logic frame_stop,
   output logic sck_rise,
   output logic sck_fall,
   output logic si_bit
);

   logic cs_n_s, sck_s, si_s;
   logic cs_q, sck_q;

   spi_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_n_s));
   spi_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s));
   spi_cmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
      .clk(clk), .rst_n(rst_n), .d(si), .q(si_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b0;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= !cs_n_s;
         sck_q <= sck_s;
      end
   end

   // Edges count only while chip-select is steady active on both samples,
   // so the idle level of the serial clock never leaks into the frame.
   assign cs_act      = !cs_n_s;
   assign frame_start = cs_act && !cs_q;
   assign frame_stop  = !cs_act && cs_q;
   assign sck_rise    = cs_act && cs_q && sck_s && !sck_q;
   assign sck_fall    = cs_act && cs_q && !sck_s && sck_q;
   assign si_bit      = si_s;

endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int ADDR_W     = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_stop,
   input  logic              sck_rise,
   input  logic              si_bit,
   output logic              op_valid,
   output logic [3:0]        cmd_kind,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              addr_done,
   output logic              frame_end,
   output logic              frame_ok,
   output logic              data_en
);

   localparam int ADDR_BITS = 8 * ADDR_BYTES;
   localparam int CNT_W     = $clog2(ADDR_BITS);
   localparam logic [CNT_W-1:0] LAST_OPC = CNT_W'(7);
   localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADDR_BITS - 1);

   generate
      if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_bytes
         $error("spi_cmd_framer: ADDR_BYTES out of range");
      end
      if (ADDR_W < 1 || ADDR_W > ADDR_BITS) begin : g_bad_w
         $error("spi_cmd_framer: ADDR_W exceeds the shifted address");
      end
   endgenerate

   frm_state_e           state;
   logic [CNT_W-1:0]     cnt;
   logic [ADDR_BITS-1:0] sr;
   logic [ADDR_BITS-1:0] sr_next;
   op_class_t            cls_c;
   cmd_kind_e            kind_q;
   logic                 rd_q;
   logic                 hdr_done;

   assign sr_next = {sr[ADDR_BITS-2:0], si_bit};

   always_comb begin
      cls_c = classify(sr_next[7:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         sr         <= '0;
         kind_q     <= K_NONE;
         rd_q       <= 1'b0;
         hdr_done   <= 1'b0;
         addr_done  <= 1'b0;
         cmd_addr   <= '0;
         op_valid   <= 1'b0;
         addr_valid <= 1'b0;
         frame_end  <= 1'b0;
         frame_ok   <= 1'b0;
      end else begin
         op_valid   <= 1'b0;
         addr_valid <= 1'b0;
         frame_end  <= 1'b0;
         if (frame_stop) begin
            if (state == ST_ADR || state == ST_TAIL) begin
               frame_end <= 1'b1;
               frame_ok  <= hdr_done;
            end
            state     <= ST_IDLE;
            cnt       <= '0;
            sr        <= '0;
            rd_q      <= 1'b0;
            hdr_done  <= 1'b0;
            addr_done <= 1'b0;
         end else if (frame_start) begin
            state     <= ST_OPC;
            cnt       <= '0;
            sr        <= '0;
            rd_q      <= 1'b0;
            hdr_done  <= 1'b0;
            addr_done <= 1'b0;
         end else if (sck_rise) begin
            case (state)
               ST_OPC: begin
                  sr <= sr_next;
                  if (cnt == LAST_OPC) begin
                     cnt <= '0;
                     if (!cls_c.known) begin
                        state <= ST_SKIP;
                     end else begin
                        op_valid <= 1'b1;
                        kind_q   <= cls_c.kind;
                        rd_q     <= cls_c.returns_data;
                        if (cls_c.needs_addr) begin
                           state <= ST_ADR;
                        end else begin
                           state    <= ST_TAIL;
                           hdr_done <= 1'b1;
                        end
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADR: begin
                  sr <= sr_next;
                  if (cnt == LAST_ADR) begin
                     cnt        <= '0;
                     cmd_addr   <= sr_next[ADDR_W-1:0];
                     addr_done  <= 1'b1;
                     hdr_done   <= 1'b1;
                     addr_valid <= 1'b1;
                     state      <= ST_TAIL;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign cmd_kind = kind_q;
   assign data_en  = (state == ST_TAIL) && rd_q;

   AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_valid, addr_valid, frame_end})); // R3

   AST_END_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !addr_done); // R4

   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |=> (!frame_end && !op_valid)); // R5

   AST_SHORT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPC && frame_stop) |=> (!frame_end && !op_valid)); // R6

   AST_OK_NEEDS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stop && state == ST_ADR) |=> !frame_ok); // R7

endmodule

// File: rtl/spi_cmd_txshift.sv
module spi_cmd_txshift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sck_fall,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              so,
   output logic              so_oe,
   output logic              tx_take
);

   localparam int BCNT_W = $clog2(DATA_W);
   localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 4) begin : g_bad_w
         $error("spi_cmd_txshift: DATA_W must be at least 4");
      end
   endgenerate

   logic [DATA_W-2:0] sh;
   logic [BCNT_W-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so      <= 1'b0;
         so_oe   <= 1'b0;
         tx_take <= 1'b0;
         sh      <= '0;
         bcnt    <= '0;
      end else if (!en) begin
         so      <= 1'b0;
         so_oe   <= 1'b0;
         tx_take <= 1'b0;
         bcnt    <= '0;
      end else begin
         so_oe   <= 1'b1;
         tx_take <= 1'b0;
         if (sck_fall) begin
            if (bcnt == '0) begin
               so      <= tx_byte[DATA_W-1];
               sh      <= tx_byte[DATA_W-2:0];
               tx_take <= 1'b1;
            end else begin
               so <= sh[DATA_W-2];
               sh <= {sh[DATA_W-3:0], 1'b0};
            end
            bcnt <= (bcnt == LAST_BIT) ? '0 : bcnt + 1'b1;
         end
      end
   end

   AST_TAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> $past(sck_fall)); // R9

   AST_SO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(so_oe) && so_oe && !$past(sck_fall)) |-> $stable(so)); // R9

endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_BYTES  = 3,
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              so,
   output logic              so_oe,
   output logic              tx_take,
   output logic              op_valid,
   output logic [3:0]        cmd_kind,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              addr_done,
   output logic              frame_end,
   output logic              frame_ok
);

   logic cs_act, frame_start, frame_stop, sck_rise, sck_fall, si_bit;
   logic data_en;

   spi_cmd_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n),
      .cs_n(cs_n), .sck(sck), .si(si),
      .cs_act(cs_act), .frame_start(frame_start), .frame_stop(frame_stop),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_bit));

   spi_cmd_framer #(.ADDR_BYTES(ADDR_BYTES), .ADDR_W(ADDR_W)) u_framer (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .frame_stop(frame_stop),
      .sck_rise(sck_rise), .si_bit(si_bit),
      .op_valid(op_valid), .cmd_kind(cmd_kind),
      .addr_valid(addr_valid), .cmd_addr(cmd_addr), .addr_done(addr_done),
      .frame_end(frame_end), .frame_ok(frame_ok), .data_en(data_en));

   spi_cmd_txshift #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .en(data_en), .sck_fall(sck_fall), .tx_byte(tx_byte),
      .so(so), .so_oe(so_oe), .tx_take(tx_take));

   AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !$past(cs_act) && !$past(cs_act, 2)) |-> !so_oe); // R8

   AST_OE_AFTER_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_oe) |-> (cmd_kind == 4'd1 || cmd_kind == 4'd8)); // R8

endmodule

// File: tb/spi_cmd_front_tb.sv
module spi_cmd_front_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        si = 1'b0;
   logic [7:0]  tx_byte = 8'h00;
   logic        so, so_oe, tx_take, op_valid, addr_valid, addr_done, frame_end, frame_ok;
   logic [3:0]  cmd_kind;
   logic [18:0] cmd_addr;

   int n_tests = 0;
   int n_fail  = 0;
   int n_op    = 0;
   int n_fe    = 0;
   int n_take  = 0;
   logic last_ok = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_cmd_front dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .tx_byte(tx_byte), .so(so), .so_oe(so_oe), .tx_take(tx_take),
      .op_valid(op_valid), .cmd_kind(cmd_kind), .addr_valid(addr_valid),
      .cmd_addr(cmd_addr), .addr_done(addr_done),
      .frame_end(frame_end), .frame_ok(frame_ok));

   always @(negedge clk) begin
      if (rst_n) begin
         if (op_valid) n_op++;
         if (tx_take) n_take++;
         if (frame_end) begin
            n_fe++;
            last_ok = frame_ok;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Starts a frame and shifts n bits of v, MSB first; cs_n stays low.
   task automatic send_bits(input bit m3, input int n, input logic [63:0] v,
                            output logic [63:0] rx, output logic [63:0] oe);
      rx = '0;
      oe = '0;
      sck = m3;
      wait_clk(HALF);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         sck = 1'b0;
         si  = v[n-1-i];
         wait_clk(HALF);
         rx = {rx[62:0], so};
         oe = {oe[62:0], so_oe};
         sck = 1'b1;
         wait_clk(HALF);
      end
   endtask

   task automatic end_frame(input bit m3);
      if (!m3) sck = 1'b0;
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic t_reset;
      chk("R8", "so_oe after reset", 64'(so_oe), 64'd0);
      chk("R4", "addr_done after reset", 64'(addr_done), 64'd0);
      chk("R3", "cmd_kind after reset", 64'(cmd_kind), 64'd0);
      chk("R7", "frame_end count after reset", 64'(n_fe), 64'd0);
   endtask

   task automatic t_erase4k_mode0;
      logic [63:0] rx, oe;
      int fe0 = n_fe;
      send_bits(1'b0, 32, {32'h0, 8'h20, 24'hFFA123}, rx, oe);
      wait_clk(HALF);
      chk("R2", "4K erase kind", 64'(cmd_kind), 64'd3);
      chk("R4", "address with top bits masked", 64'(cmd_addr), 64'h7A123);
      chk("R4", "addr_done during frame", 64'(addr_done), 64'd1);
      chk("R8", "so_oe low through header", oe[31:0], 64'd0);
      end_frame(1'b0);
      chk("R7", "frame_end once", 64'(n_fe - fe0), 64'd1);
      chk("R7", "frame_ok full header", 64'(last_ok), 64'd1);
      chk("R4", "addr_done cleared at release", 64'(addr_done), 64'd0);
   endtask

   task automatic t_erase64k_mode3;
      logic [63:0] rx, oe;
      int op0 = n_op;
      send_bits(1'b1, 32, {32'h0, 8'hD8, 24'h012345}, rx, oe);
      end_frame(1'b1);
      chk("R1", "mode 3 kind", 64'(cmd_kind), 64'd5);
      chk("R1", "mode 3 address", 64'(cmd_addr), 64'h12345);
      chk("R3", "single op_valid", 64'(n_op - op0), 64'd1);
      chk("R7", "mode 3 frame_ok", 64'(last_ok), 64'd1);
   endtask

   task automatic t_short_opcode;
      logic [63:0] rx, oe;
      int op0 = n_op;
      int fe0 = n_fe;
      send_bits(1'b0, 5, 64'b10101, rx, oe);
      end_frame(1'b0);
      chk("R6", "no op_valid on short opcode", 64'(n_op - op0), 64'd0);
      chk("R6", "no frame_end on short opcode", 64'(n_fe - fe0), 64'd0);
      chk("R6", "kind kept after short opcode", 64'(cmd_kind), 64'd5);
   endtask

   task automatic t_unknown_opcode;
      logic [63:0] rx, oe;
      int op0 = n_op;
      int fe0 = n_fe;
      send_bits(1'b1, 32, {32'h0, 8'hAB, 24'h0F0F0F}, rx, oe);
      wait_clk(HALF);
      chk("R5", "addr_done stays low", 64'(addr_done), 64'd0);
      end_frame(1'b1);
      chk("R5", "no op_valid on unknown code", 64'(n_op - op0), 64'd0);
      chk("R5", "no frame_end on unknown code", 64'(n_fe - fe0), 64'd0);
      chk("R5", "address untouched", 64'(cmd_addr), 64'h12345);
      chk("R5", "kind untouched", 64'(cmd_kind), 64'd5);
   endtask

   task automatic t_truncated_address;
      logic [63:0] rx, oe;
      int fe0 = n_fe;
      send_bits(1'b0, 24, {40'h0, 8'h52, 16'h1234}, rx, oe);
      wait_clk(HALF);
      chk("R4", "addr_done low on 16 address bits", 64'(addr_done), 64'd0);
      end_frame(1'b0);
      chk("R2", "32K erase kind", 64'(cmd_kind), 64'd4);
      chk("R7", "frame_end on truncated frame", 64'(n_fe - fe0), 64'd1);
      chk("R7", "frame_ok low on truncated frame", 64'(last_ok), 64'd0);
      chk("R4", "address kept on truncation", 64'(cmd_addr), 64'h12345);
   endtask

   task automatic t_write_enable;
      logic [63:0] rx, oe;
      send_bits(1'b1, 8, 64'h06, rx, oe);
      wait_clk(2 * HALF);
      chk("R8", "no output enable for write enable", 64'(so_oe), 64'd0);
      end_frame(1'b1);
      chk("R2", "write enable kind", 64'(cmd_kind), 64'd6);
      chk("R7", "frame_ok without address", 64'(last_ok), 64'd1);
   endtask

   task automatic t_status_read;
      logic [63:0] rx, oe;
      int tk0 = n_take;
      tx_byte = 8'hC3;
      send_bits(1'b1, 24, {40'h0, 8'h05, 16'h0}, rx, oe);
      end_frame(1'b1);
      chk("R2", "status read kind", 64'(cmd_kind), 64'd8);
      chk("R9", "status bytes on so", rx[15:0], 64'hC3C3);
      chk("R8", "so_oe pattern", oe[23:0], 64'h00FFFF);
      chk("R9", "two byte loads", 64'(n_take - tk0), 64'd2);
      chk("R8", "so_oe off after release", 64'(so_oe), 64'd0);
   endtask

   task automatic t_read_data;
      logic [63:0] rx, oe;
      tx_byte = 8'h5A;
      send_bits(1'b0, 40, {24'h0, 8'h03, 24'h00ABCD, 8'h00}, rx, oe);
      end_frame(1'b0);
      chk("R2", "read kind", 64'(cmd_kind), 64'd1);
      chk("R4", "read address", 64'(cmd_addr), 64'h0ABCD);
      chk("R9", "read data on so", rx[7:0], 64'h5A);
      chk("R8", "so_oe only after address", oe[39:0], 64'hFF);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_erase4k_mode0();
      t_erase64k_mode3();
      t_short_opcode();
      t_unknown_opcode();
      t_truncated_address();
      t_write_enable();
      t_status_read();
      t_read_data();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule